// File: doc/BRIEF.md
# Data-Memory Address Generator and Access Controller

This block sits between the instruction decoder of an 8-bit controller and its data RAM. For every data access it picks one of two address forms. A non-zero file field from the instruction is direct: the three upper bits of the file select register act as a bank number above the five-bit file field. File field zero names the indirect register, so the access goes to the full 8-bit file select register value instead.

One corner case is handled apart. If an indirect access points back at the indirect register itself, it must not reach memory. Such a read returns zero and raises no output enable. Such a write raises no write strobe. The block registers the RAM address, the write data and the strobes, and hands read data back to the ALU with a valid flag.

A build-time parameter selects the RAM type. With asynchronous RAM, read data comes back in the cycle after the request. With synchronous RAM, it comes back two cycles after the request.

Top module: `dmem_access`

## Requirements
- R1: While reset is asserted, `ram_we`, `ram_oe` and `rd_valid` are all 0.
- R2: A request with a non-zero file field drives `ram_addr` = {fsr[7:5], file_sel[4:0]} in the cycle after the request.
- R3: A request with file field 0 drives `ram_addr` = the full `fsr` value in the cycle after the request.
- R4: A write with file field 0 and fsr[4:0] = 0 produces no `ram_we` pulse.
- R5: A read with file field 0 and fsr[4:0] = 0 raises no `ram_oe`. It still returns `rd_valid` with `rd_data` = 8'h00 at the normal read latency.
- R6: Every other write raises `ram_we` for exactly the one cycle after the request, with `ram_wdata` equal to the request's write data.
- R7: Every other read raises `ram_oe` for exactly the one cycle after the request. `ram_we` and `ram_oe` are never high together.
- R8: With SYNC_RAM=1, `rd_valid` and `rd_data` appear two cycles after the read request. With SYNC_RAM=0 they appear one cycle after it. `rd_data` carries the RAM word as it stood after all earlier writes.
- R9: A cycle with `req_valid` low leads to no strobe in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Data access requested this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| file_sel | input | 5 | File field of the instruction |
| fsr | input | 8 | Current file select register value |
| wr_data | input | 8 | Data to store on a write |
| ram_rdata | input | 8 | Data returned by the RAM |
| ram_addr | output | 8 | RAM address |
| ram_wdata | output | 8 | RAM write data |
| ram_we | output | 1 | RAM write strobe |
| ram_oe | output | 1 | RAM output enable |
| rd_valid | output | 1 | Read data for the ALU is valid |
| rd_data | output | 8 | Read data for the ALU |

## Verification
With synchronous RAM, the data of one read is returned in the same cycle as the write strobe of the request that follows it. The bench provokes this with a read and a write to the same location issued back to back. It passes only if the returned word is the value from before the write, and the strobe and the data are both correct in that shared cycle. The bench runs an asynchronous instance alongside on the same stimulus. Against both, a behavioural model with a shadow memory and latency queues judges every output on every clock.

// File: rtl/dmem_access_pkg.sv
package dmem_access_pkg;
    localparam int DM_ADDR_W = 8;
    localparam int DM_DATA_W = 8;
    localparam int DM_FILE_W = 5;

    typedef struct packed {
        logic we;
        logic oe;
        logic rd;
        logic zero;
    } strobe_t;
endpackage

// File: rtl/dmem_addr_gen.sv
module dmem_addr_gen #(
    parameter int ADDR_W    = 8,
    parameter int FILE_W    = 5,
    parameter int INDF_ADDR = 0
) (
    input  logic [FILE_W-1:0] file_sel,
    input  logic [ADDR_W-1:0] fsr,
    output logic [ADDR_W-1:0] eff_addr,
    output logic              is_self
);
    localparam int BANK_W = ADDR_W - FILE_W;
    localparam logic [FILE_W-1:0] INDF_FIELD = FILE_W'(INDF_ADDR);

    logic [ADDR_W-1:0] direct_addr;
    logic              indirect;

    generate
        if (BANK_W > 0) begin : g_banked
            assign direct_addr = {fsr[ADDR_W-1:FILE_W], file_sel};
        end else begin : g_flat
            assign direct_addr = file_sel[ADDR_W-1:0];
        end
    endgenerate

    always_comb begin
        indirect = (file_sel == INDF_FIELD);
        eff_addr = indirect ? fsr : direct_addr;
        is_self  = indirect && (fsr[FILE_W-1:0] == INDF_FIELD);
    end
endmodule

// File: rtl/dmem_access_ctrl.sv
module dmem_access_ctrl
    import dmem_access_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] eff_addr,
    input  logic              is_self,
    input  logic [DATA_W-1:0] wr_data,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    output strobe_t           strb
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        strobe_t           s;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d   = ctrl_q;
        ctrl_d.s = '0;
        if (req_valid) begin
            ctrl_d.addr = eff_addr;
            if (req_write) begin
                ctrl_d.wdata = wr_data;
                ctrl_d.s.we  = !is_self;
            end else begin
                ctrl_d.s.rd   = 1'b1;
                ctrl_d.s.oe   = !is_self;
                ctrl_d.s.zero = is_self;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign ram_addr  = ctrl_q.addr;
    assign ram_wdata = ctrl_q.wdata;
    assign strb      = ctrl_q.s;

    assert_we_from_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.s.we |-> $past(req_valid && req_write && !is_self));
    assert_self_write_blocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && req_write && is_self) |-> !ctrl_q.s.we);
    assert_oe_from_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.s.oe |-> $past(req_valid && !req_write && !is_self));
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!req_valid) |-> !(ctrl_q.s.we || ctrl_q.s.oe));
endmodule

// File: rtl/dmem_read_return.sv
module dmem_read_return
    import dmem_access_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter bit SYNC_RAM = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  strobe_t           strb,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    typedef struct packed {
        logic valid;
        logic zero;
    } ret_t;

    generate
        if (SYNC_RAM) begin : g_sync
            ret_t ret_d, ret_q;

            always_comb begin
                ret_d.valid = strb.rd;
                ret_d.zero  = strb.zero;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) ret_q <= '0;
                else        ret_q <= ret_d;
            end

            assign rd_valid = ret_q.valid;
            assign rd_data  = ret_q.zero ? '0 : ram_rdata;

            assert_sync_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
                ret_q.valid |-> $past(strb.rd));
        end else begin : g_async
            assign rd_valid = strb.rd;
            assign rd_data  = strb.zero ? '0 : ram_rdata;
        end
    endgenerate
endmodule

// File: rtl/dmem_access.sv
module dmem_access
    import dmem_access_pkg::*;
#(
    parameter int ADDR_W    = DM_ADDR_W,
    parameter int DATA_W    = DM_DATA_W,
    parameter int FILE_W    = DM_FILE_W,
    parameter int INDF_ADDR = 0,
    parameter bit SYNC_RAM  = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [FILE_W-1:0] file_sel,
    input  logic [ADDR_W-1:0] fsr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    output logic              ram_we,
    output logic              ram_oe,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    logic [ADDR_W-1:0] eff_addr;
    logic              is_self;
    strobe_t           strb;

    dmem_addr_gen #(.ADDR_W(ADDR_W), .FILE_W(FILE_W), .INDF_ADDR(INDF_ADDR)) u_addr (
        .file_sel(file_sel), .fsr(fsr), .eff_addr(eff_addr), .is_self(is_self)
    );

    dmem_access_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .eff_addr(eff_addr), .is_self(is_self), .wr_data(wr_data),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata), .strb(strb)
    );

    dmem_read_return #(.DATA_W(DATA_W), .SYNC_RAM(SYNC_RAM)) u_ret (
        .clk(clk), .rst_n(rst_n), .strb(strb), .ram_rdata(ram_rdata),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    assign ram_we = strb.we;
    assign ram_oe = strb.oe;

    assert_direct_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && file_sel != FILE_W'(INDF_ADDR)) |->
        ram_addr == {$past(fsr[ADDR_W-1:FILE_W]), $past(file_sel)});
    assert_indirect_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && file_sel == FILE_W'(INDF_ADDR)) |-> ram_addr == $past(fsr));
    assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ram_we, ram_oe}));
endmodule

// File: tb/tb_dmem_access.sv
module tb_dmem_access;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0, req_write = 1'b0;
    logic [4:0] file_sel = '0;
    logic [7:0] fsr = '0, wr_data = '0;

    logic [7:0] s_rdata, s_addr, s_wdata, s_rd;
    logic       s_we, s_oe, s_rv;
    logic [7:0] a_rdata, a_addr, a_wdata, a_rd;
    logic       a_we, a_oe, a_rv;

    logic [7:0] mem_s [256];
    logic [7:0] mem_a [256];
    logic [7:0] shadow [256];

    int checks = 0, fails = 0;
    int q_sync[$], q_async[$];
    logic       exp_we = 0, exp_oe = 0;
    logic [7:0] exp_addr = 0, exp_wdata = 0;

    always #2 clk = ~clk;

    dmem_access #(.SYNC_RAM(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .file_sel(file_sel), .fsr(fsr), .wr_data(wr_data), .ram_rdata(s_rdata),
        .ram_addr(s_addr), .ram_wdata(s_wdata), .ram_we(s_we), .ram_oe(s_oe),
        .rd_valid(s_rv), .rd_data(s_rd));

    dmem_access #(.SYNC_RAM(1'b0)) dut_a (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .file_sel(file_sel), .fsr(fsr), .wr_data(wr_data), .ram_rdata(a_rdata),
        .ram_addr(a_addr), .ram_wdata(a_wdata), .ram_we(a_we), .ram_oe(a_oe),
        .rd_valid(a_rv), .rd_data(a_rd));

    always @(posedge clk) begin
        if (s_we) mem_s[s_addr] <= s_wdata;
        if (s_oe) s_rdata <= mem_s[s_addr];
        if (a_we) mem_a[a_addr] <= a_wdata;
    end
    assign a_rdata = mem_a[a_addr];

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic compare();
        int es, ea;
        es = q_sync.pop_front();
        ea = q_async.pop_front();
        check(s_we == exp_we && a_we == exp_we, "R6/R4 we", {s_we, a_we}, {exp_we, exp_we});
        check(s_oe == exp_oe && a_oe == exp_oe, "R7/R5 oe", {s_oe, a_oe}, {exp_oe, exp_oe});
        if (exp_we || exp_oe)
            check(s_addr == exp_addr && a_addr == exp_addr, "R2/R3 addr", s_addr, exp_addr);
        if (exp_we)
            check(s_wdata == exp_wdata && a_wdata == exp_wdata, "R6 wdata", s_wdata, exp_wdata);
        check(s_rv == (es >= 0), "R8 sync rd_valid", s_rv, es >= 0);
        if (es >= 0) check(s_rd == es[7:0], "R8/R5 sync rd_data", s_rd, es);
        check(a_rv == (ea >= 0), "R8 async rd_valid", a_rv, ea >= 0);
        if (ea >= 0) check(a_rd == ea[7:0], "R8/R5 async rd_data", a_rd, ea);
    endtask

    task automatic step(input logic v, input logic w, input logic [4:0] f,
                        input logic [7:0] r, input logic [7:0] d);
        logic       self;
        logic [7:0] addr;
        int         ent;
        @(negedge clk);
        compare();
        req_valid = v; req_write = w; file_sel = f; fsr = r; wr_data = d;
        self = (f == 5'd0) && (r[4:0] == 5'd0);
        addr = (f == 5'd0) ? r : {r[7:5], f};
        exp_we = v && w && !self;
        exp_oe = v && !w && !self;
        exp_addr = addr;
        exp_wdata = d;
        ent = -1;
        if (v && !w) ent = self ? 0 : int'(shadow[addr]);
        if (exp_we) shadow[addr] = d;
        q_sync.push_back(ent);
        q_async.push_back(ent);
    endtask

    initial begin
        #400000;
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem_s[i] = 8'(i * 7 + 3);
            mem_a[i] = 8'(i * 7 + 3);
            shadow[i] = 8'(i * 7 + 3);
        end
        q_sync = '{-1, -1};
        q_async = '{-1};
        repeat (3) @(negedge clk);
        check(!s_we && !s_oe && !s_rv && !a_we && !a_oe && !a_rv, "R1 reset",
              {s_we, s_oe, s_rv}, 0);
        rst_n = 1'b1;
        // R2: direct writes in several banks, then reads back
        step(1, 1, 5'd9, 8'h00, 8'hA5);
        step(1, 1, 5'd9, 8'hE0, 8'h5A);
        step(1, 0, 5'd9, 8'h00, 8'h00);
        step(1, 0, 5'd9, 8'hE3, 8'h00);
        // R3: indirect write and read
        step(1, 1, 5'd0, 8'h47, 8'h3C);
        step(1, 0, 5'd0, 8'h47, 8'h00);
        step(1, 0, 5'd7, 8'h40, 8'h00);
        // R4/R5: indirect to itself, in two banks
        step(1, 1, 5'd0, 8'h00, 8'hFF);
        step(1, 1, 5'd0, 8'hA0, 8'hFF);
        step(1, 0, 5'd0, 8'h60, 8'h00);
        step(1, 0, 5'd0, 8'h00, 8'h00);
        // R9: idle cycles
        step(0, 1, 5'd3, 8'h00, 8'h11);
        step(0, 0, 5'd0, 8'h55, 8'h00);
        // R8: read then write same location back to back, then reread
        step(1, 0, 5'd12, 8'h20, 8'h00);
        step(1, 1, 5'd12, 8'h20, 8'h77);
        step(1, 0, 5'd12, 8'h20, 8'h00);
        step(1, 1, 5'd0, 8'h2C, 8'h99);
        step(1, 0, 5'd12, 8'h20, 8'h00);
        // mixed random traffic
        for (int n = 0; n < 3000; n++) begin
            logic [4:0] rf;
            logic [7:0] rr;
            rf = ($urandom % 4 == 0) ? 5'd0 : 5'($urandom);
            rr = ($urandom % 6 == 0) ? {3'($urandom), 5'd0} : 8'($urandom);
            step(($urandom % 5) != 0, $urandom % 2 == 1, rf, rr, 8'($urandom));
        end
        repeat (3) step(0, 0, 5'd0, 8'h00, 8'h00);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule